// File: doc/BRIEF.md
# 16-bit Add/And/Invert Arithmetic Unit

This block is the arithmetic stage of a small 16-bit processor. It takes the instruction word being executed and the values of two source registers. It returns one 16-bit result, purely combinationally. The top four bits of the instruction choose between a two's-complement sum, a bitwise conjunction and a bitwise inversion. For the two-operand operations, bit 5 of the instruction picks the second operand. That operand is either the second source register or a 5-bit signed constant taken from the low bits of the instruction and widened to 16 bits.

All three operations are formed in parallel on every input change. A final selector driven by the decoded opcode forwards one of them. The surrounding datapath uses the result as the write-back value for the destination register. That datapath also decides whether to commit the value. This block has no state, no clock and no condition codes.

Top module: `alu3_core`

## Requirements
- R1: The opcode is `instr[15:12]`: `4'b0001` selects ADD, `4'b0101` selects AND, `4'b1001` selects NOT. The result reflects the current inputs with no clock cycle of delay.
- R2: ADD with `instr[5]=0` returns `src_a + src_b`.
- R3: ADD with `instr[5]=1` returns `src_a` plus `instr[4:0]` sign-extended to 16 bits (bit 4 copied into bits 15:5).
- R4: AND with `instr[5]=0` returns `src_a & src_b`.
- R5: AND with `instr[5]=1` returns `src_a` ANDed with `instr[4:0]` sign-extended to 16 bits.
- R6: NOT returns `~src_a`. Neither `src_b` nor `instr[5:0]` has any effect on it.
- R7: Any opcode other than the three in R1 returns 16'h0000.
- R8: ADD wraps modulo 2^16 and gives no carry or overflow indication. For example, 16'hFFFF + 1 yields 16'h0000.
- R9: `instr[11:6]` has no effect on the result for any opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Instruction word: opcode in [15:12], operand select in [5], signed constant in [4:0] |
| src_a | input | 16 | First source register value |
| src_b | input | 16 | Second source register value |
| result | output | 16 | Selected operation result |

## Verification
Every result is due in the same cycle its inputs are applied, because no register lies between the ports. The bench drives a new instruction and operand pair just after a rising edge. It compares `result` with a behavioural model at the following falling edge, half a period later, when the logic has long settled. For the "no effect" rules, the bench first sets a baseline. It then changes only the field that must be ignored and checks at the next falling edge that the output still equals the baseline.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

    localparam int WORD_W      = 16;
    localparam int IMM_W       = 5;
    localparam int OPC_W       = 4;
    localparam int OPC_LSB     = WORD_W - OPC_W;
    localparam int IMM_SEL_BIT = IMM_W;
    localparam int EXT_W       = WORD_W - IMM_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD = 4'b0001,
        OPC_AND = 4'b0101,
        OPC_NOT = 4'b1001
    } opcode_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_ADD,
        KIND_AND,
        KIND_INV
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic             use_imm;
        logic [IMM_W-1:0] imm;
    } alu_ctrl_t;

    typedef struct packed {
        word_t sum;
        word_t conj;
        word_t inv;
    } unit_res_t;

    function automatic word_t widen_imm(input logic [IMM_W-1:0] field);
        return {{EXT_W{field[IMM_W-1]}}, field};
    endfunction

    function automatic op_kind_e classify(input logic [OPC_W-1:0] code);
        op_kind_e k;
        case (code)
            OPC_ADD: k = KIND_ADD;
            OPC_AND: k = KIND_AND;
            OPC_NOT: k = KIND_INV;
            default: k = KIND_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/alu3_decode.sv
module alu3_decode
    import alu3_pkg::*;
(
    input  word_t     instr,
    output alu_ctrl_t ctrl
);

    logic [OPC_W-1:0] opc_field;
    logic             unused_fields;

    assign opc_field     = instr[OPC_LSB +: OPC_W];
    assign unused_fields = ^instr[OPC_LSB-1:IMM_SEL_BIT+1];

    always_comb begin
        ctrl.kind    = classify(opc_field);
        ctrl.use_imm = instr[IMM_SEL_BIT];
        ctrl.imm     = instr[IMM_W-1:0];
    end

endmodule

// File: rtl/alu3_operand.sv
module alu3_operand
    import alu3_pkg::*;
(
    input  alu_ctrl_t ctrl,
    input  word_t     src_b,
    output word_t     opnd_b
);

    word_t imm_wide;

    assign imm_wide = widen_imm(ctrl.imm);

    always_comb begin
        if (ctrl.use_imm) begin
            opnd_b = imm_wide;
        end else begin
            opnd_b = src_b;
        end
    end

endmodule

// File: rtl/alu3_units.sv
module alu3_units
    import alu3_pkg::*;
(
    input  word_t     opnd_a,
    input  word_t     opnd_b,
    output unit_res_t res
);

    word_t conj_bits;
    word_t inv_bits;

    genvar gi;
    generate
        for (gi = 0; gi < WORD_W; gi++) begin : g_bit
            assign conj_bits[gi] = opnd_a[gi] & opnd_b[gi];
            assign inv_bits[gi]  = ~opnd_a[gi];
        end
    endgenerate

    always_comb begin
        res.sum  = opnd_a + opnd_b;
        res.conj = conj_bits;
        res.inv  = inv_bits;
    end

endmodule

// File: rtl/alu3_select.sv
module alu3_select
    import alu3_pkg::*;
(
    input  op_kind_e  kind,
    input  unit_res_t res,
    output word_t     y
);

    always_comb begin
        case (kind)
            KIND_ADD: y = res.sum;
            KIND_AND: y = res.conj;
            KIND_INV: y = res.inv;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/alu3_core.sv
module alu3_core
    import alu3_pkg::*;
(
    input  logic [15:0] instr,
    input  logic [15:0] src_a,
    input  logic [15:0] src_b,
    output logic [15:0] result
);

    alu_ctrl_t ctrl;
    word_t     opnd_b;
    unit_res_t res;

    alu3_decode u_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    alu3_operand u_operand (
        .ctrl   (ctrl),
        .src_b  (src_b),
        .opnd_b (opnd_b)
    );

    alu3_units u_units (
        .opnd_a (src_a),
        .opnd_b (opnd_b),
        .res    (res)
    );

    alu3_select u_select (
        .kind (ctrl.kind),
        .res  (res),
        .y    (result)
    );

endmodule

// File: rtl/alu3_core_chk.sv
module alu3_core_chk (
    input logic [15:0] instr,
    input logic [15:0] src_a,
    input logic [15:0] src_b,
    input logic [15:0] result
);

    logic [15:0] imm16;
    logic [15:0] b_sel;
    logic [3:0]  code;

    assign code  = instr[15:12];
    assign imm16 = {{11{instr[4]}}, instr[4:0]};
    assign b_sel = instr[5] ? imm16 : src_b;

    always_comb begin
        if (code == 4'b0001 && !instr[5]) begin
            a_r2_add_reg: assert (result == 16'(src_a + src_b))
                else $error("R2 add/reg mismatch");
        end
        if (code == 4'b0001 && instr[5]) begin
            a_r3_add_imm: assert (result == 16'(src_a + imm16))
                else $error("R3 add/imm mismatch");
        end
        if (code == 4'b0101) begin
            a_r4_and_op: assert (result == (src_a & b_sel))
                else $error("R4/R5 and mismatch");
        end
        if (code == 4'b1001) begin
            a_r6_not_op: assert (result == ~src_a)
                else $error("R6 not mismatch");
        end
        if (code != 4'b0001 && code != 4'b0101 && code != 4'b1001) begin
            a_r7_zero_other: assert (result == 16'h0000)
                else $error("R7 nonzero for unlisted opcode");
        end
    end

endmodule

bind alu3_core alu3_core_chk u_chk (
    .instr  (instr),
    .src_a  (src_a),
    .src_b  (src_b),
    .result (result)
);

// File: tb/sim_alu3_core.sv
`timescale 1ns/1ps
module sim_alu3_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic [15:0] src_a = 16'h0000;
    logic [15:0] src_b = 16'h0000;
    logic [15:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    alu3_core u0 (
        .instr  (instr),
        .src_a  (src_a),
        .src_b  (src_b),
        .result (result)
    );

    function automatic logic [15:0] model(input logic [15:0] i, input logic [15:0] a,
                                          input logic [15:0] b);
        int opv;
        int bv;
        int imm;
        int sum;
        opv = int'(i[15:12]);
        imm = int'(i[4:0]);
        if (imm >= 16) imm = imm - 32;
        bv  = i[5] ? (imm & 32'hFFFF) : int'(b);
        if (opv == 1) begin
            sum = int'(a) + bv;
            return 16'(sum % 65536);
        end else if (opv == 5) begin
            return 16'(int'(a) & bv);
        end else if (opv == 9) begin
            return 16'(65535 - int'(a));
        end
        return 16'h0000;
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_tests++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: instr=%h a=%h b=%h got %h expected %h",
                     tag, instr, src_a, src_b, result, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [15:0] i,
                         input logic [15:0] a, input logic [15:0] b);
        @(posedge clk);
        #1;
        instr = i;
        src_a = a;
        src_b = b;
        @(negedge clk);
        check(tag, model(i, a, b));
    endtask

    task automatic apply_exp(input string tag, input logic [15:0] i,
                             input logic [15:0] a, input logic [15:0] b,
                             input logic [15:0] exp);
        @(posedge clk);
        #1;
        instr = i;
        src_a = a;
        src_b = b;
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] base;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset idle", 16'h0000);

        // R1/R2: ADD reg, opcode 0001 bit5=0
        apply_exp("R2 add reg", 16'h1000, 16'h1234, 16'h0101, 16'h1335);
        apply_exp("R1 add same-cycle", 16'h1000, 16'h0007, 16'h0003, 16'h000A);
        // R8 wrap
        apply_exp("R8 wrap", 16'h1000, 16'hFFFF, 16'h0001, 16'h0000);
        apply_exp("R8 wrap big", 16'h1000, 16'h8000, 16'h8000, 16'h0000);
        // R3: ADD imm
        apply_exp("R3 add imm +15", 16'h102F, 16'h0010, 16'hAAAA, 16'h001F);
        apply_exp("R3 add imm -1", 16'h103F, 16'h0010, 16'h5555, 16'h000F);
        apply_exp("R3 add imm -16", 16'h1030, 16'h0000, 16'h0000, 16'hFFF0);
        // R4: AND reg
        apply_exp("R4 and reg", 16'h5000, 16'hF0F0, 16'h3C3C, 16'h3030);
        // R5: AND imm
        apply_exp("R5 and imm neg", 16'h5030, 16'h1234, 16'h0000, 16'h1230);
        apply_exp("R5 and imm pos", 16'h502F, 16'hFFFF, 16'h0000, 16'h000F);
        // R6: NOT
        apply_exp("R6 not", 16'h9000, 16'h00FF, 16'h1234, 16'hFF00);
        apply_exp("R6 not ignores b/imm", 16'h903F, 16'h00FF, 16'hFFFF, 16'hFF00);
        // R7: other opcodes
        for (int k = 0; k < 16; k++) begin
            if (k != 1 && k != 5 && k != 9) begin
                apply_exp("R7 other opcode", {4'(k), 12'h03F}, 16'hFFFF, 16'hFFFF, 16'h0000);
            end
        end
        // R9: bits 11:6 ignored
        apply("R9 baseline add", 16'h1000, 16'h4321, 16'h1111);
        base = result;
        apply_exp("R9 add fields", 16'h1FC0, 16'h4321, 16'h1111, base);
        apply("R9 baseline and", 16'h5025, 16'hABCD, 16'h0000);
        base = result;
        apply_exp("R9 and fields", 16'h5AA5, 16'hABCD, 16'h0000, base);
        // R6 src_b change has no effect
        apply("R6 baseline", 16'h9000, 16'h5A5A, 16'h0000);
        base = result;
        apply_exp("R6 src_b ignored", 16'h9000, 16'h5A5A, 16'hFFFF, base);
        apply_exp("R6 imm bits ignored", 16'h9015, 16'h5A5A, 16'hFFFF, base);

        // mixed patterns against the model
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ri;
            logic [3:0]  sel;
            sel = 4'($urandom_range(0, 3));
            ri  = 16'($urandom);
            case (sel)
                4'd0: ri[15:12] = 4'b0001;
                4'd1: ri[15:12] = 4'b0101;
                4'd2: ri[15:12] = 4'b1001;
                default: ;
            endcase
            apply("R1-mix R2 R3 R4 R5 R6 R7", ri, 16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule